// File: doc/BRIEF.md
# TLB random-index write unit

This block holds a small fully associative translation buffer whose entries each map an even and an odd page. It carries out one operation: writing an entry chosen by a free-running random index. The entry is built from staged control values: an entry-high group (VPN2, ASID, region, invalidate flag), two entry-low groups (PFN, cache attribute, dirty, valid, global), a page mask and guest control fields. The entry is transformed on the way in rather than copied. Address fields are cut down to the page size. The global bit is the AND of the two entry-low global bits, or is forced by a root-mode guest override. A hardware-invalid flag is kept per entry.

A write is started by a one-cycle `start` strobe. It first passes an access check and a configuration check, either of which can abort it with an exception flag. A page mask equal to the fixed page size sends the write into a small fixed-size array, indexed by VPN2 bits. Any other mask sends it into the variable-size array at the random index. Other live entries that would match the new one are invalidated in the same cycle, and no machine check is raised. A combinational probe port shows any entry so that the surrounding logic can inspect the array.

Top module: `tlbw_top`

## Requirements
- R1: When `cpEn` is 0, a start raises `excCpu` together with `done`, leaves `excRi` at 0 and changes no entry.
- R2: When `cpEn` is 1 and `vzPresent` is 0, a start raises `excRi` together with `done` and changes no entry. `excCpu` and `excRi` are never high together.
- R3: The written entry's `g` bit is `lo0G & lo1G` when the guest override of R4 does not apply.
- R4: `g` is forced to 1 when `guestEn`=1, `radDis`=0, `rootMode`=1 and `rootGid`≠0.
- R5: The stored `vpn2`, `pfn0` and `pfn1` equal the inputs ANDed with the inverted page mask, which is zero-extended over the low MASKW bits. `mask`, `region` and `asid` are stored unchanged.
- R6: `c0/d0/v0` come from entry-low 0 and `c1/d1/v1` come from entry-low 1.
- R7: With `invEn`=1 the entry's `hwInv` takes `hiInv`. With `invEn`=0 the entry's previous `hwInv` is kept.
- R8: With `guestEn`=1 the entry's `gid` takes `rootGid`. With `guestEn`=0 the previous `gid` is kept.
- R9: A `pageMask` different from FIX_MASK writes the variable array at the current `randIdx` (0..VTLB_N-1). A `pageMask` equal to FIX_MASK writes index VTLB_N + `hiVpn2[MASKW +: log2(FTLB_N)]`.
- R10: During a write, every other entry with `hwInv`=0 matches when its VPN2 and the new VPN2 are equal outside the OR of both masks, and either the ASIDs are equal or either global bit is 1. Each such entry gets `hwInv`=1. The write completes with `done` and no exception flag.
- R11: `randIdx` resets to VTLB_N-1. Every cycle it decrements, and when it is at or below `wired` it returns to VTLB_N-1 on the next cycle.
- R12: `done` is high exactly in the cycle after `start`. After a completed write, `wrIdx` holds the index written.
- R13: After reset every entry has `hwInv`=1 and all other fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle write request |
| cpEn | input | 1 | Coprocessor access enabled |
| vzPresent | input | 1 | Virtualization configuration bit |
| invEn | input | 1 | Hardware-invalidate feature enabled |
| guestEn | input | 1 | Guest-ID support enabled |
| radDis | input | 1 | Root-ASID-disable control |
| rootMode | input | 1 | Core is in root mode |
| rootGid | input | GIDW | Root guest ID |
| wired | input | log2(VTLB_N) | Random-index floor |
| hiVpn2 | input | VPN2W | Entry-high VPN2 |
| hiAsid | input | ASIDW | Entry-high ASID |
| hiRegion | input | 2 | Entry-high region bits |
| hiInv | input | 1 | Entry-high invalidate flag |
| lo0Pfn | input | PFNW | Even-page PFN |
| lo0C | input | CACHEW | Even-page cache attribute |
| lo0D | input | 1 | Even-page dirty |
| lo0V | input | 1 | Even-page valid |
| lo0G | input | 1 | Even-page global |
| lo1Pfn | input | PFNW | Odd-page PFN |
| lo1C | input | CACHEW | Odd-page cache attribute |
| lo1D | input | 1 | Odd-page dirty |
| lo1V | input | 1 | Odd-page valid |
| lo1G | input | 1 | Odd-page global |
| pageMask | input | MASKW | Page mask |
| probeIdx | input | log2(VTLB_N+FTLB_N) | Entry to show on `probeEntry` |
| probeEntry | output | $bits(tlbEntry_t) | Entry contents, packed in the package struct order |
| done | output | 1 | Start acknowledged (cycle after start) |
| excCpu | output | 1 | Coprocessor-unusable flag, with done |
| excRi | output | 1 | Reserved-instruction flag, with done |
| wrIdx | output | log2(VTLB_N+FTLB_N) | Index of the last entry written |
| randIdx | output | log2(VTLB_N) | Current random index |

## Verification
The bench builds the block with VTLB_N=8, FTLB_N=4 and FIX_MASK=0, using 8-bit VPN2 and PFN and a 4-bit mask. A wired floor of 2 gives a short wrap cycle, so R11's wrap is reached several times within a few cycles. A zero mask reaches the fixed array at predictable indices 8 to 11. Nonzero masks of 1 and 3 exercise the partial masking of addresses and the combined-mask duplicate compare. The eight-entry random range lets the duplicate tests place three or more live entries at distinct slots and see which ones are invalidated.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  parameter int VPN2W  = 8;
  parameter int PFNW   = 8;
  parameter int ASIDW  = 4;
  parameter int MASKW  = 4;
  parameter int GIDW   = 3;
  parameter int CACHEW = 3;

  typedef struct packed {
    logic              hwInv;
    logic [GIDW-1:0]   gid;
    logic [1:0]        region;
    logic [VPN2W-1:0]  vpn2;
    logic [MASKW-1:0]  mask;
    logic [ASIDW-1:0]  asid;
    logic              g;
    logic [PFNW-1:0]   pfn0;
    logic [PFNW-1:0]   pfn1;
    logic [CACHEW-1:0] c0;
    logic [CACHEW-1:0] c1;
    logic              d0;
    logic              d1;
    logic              v0;
    logic              v1;
  } tlbEntry_t;

  typedef struct packed {
    logic act;
    logic wrEn;
    logic useFix;
    logic excCpu;
    logic excRi;
  } ctrlStb_t;
endpackage

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl
  import tlbw_pkg::*;
#(
  parameter int VTLB_N = 8,
  parameter int FTLB_N = 4,
  parameter logic [MASKW-1:0] FIX_MASK = '0,
  localparam int IDXW  = $clog2(VTLB_N + FTLB_N),
  localparam int VIDXW = $clog2(VTLB_N),
  localparam int FSELW = $clog2(FTLB_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cpEn,
  input  logic             vzPresent,
  input  logic [MASKW-1:0] pageMask,
  input  logic [VPN2W-1:0] hiVpn2,
  input  logic [VIDXW-1:0] wired,
  output ctrlStb_t         stb,
  output logic [IDXW-1:0]  tgtIdx,
  output logic [VIDXW-1:0] randIdx
);
  localparam logic [VIDXW-1:0] LAST = VIDXW'(VTLB_N - 1);

  logic [VIDXW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)              cnt <= LAST;
    else if (cnt <= wired)  cnt <= LAST;
    else                    cnt <= cnt - 1'b1;
  end

  always_comb begin
    stb.act    = start;
    stb.excCpu = start & ~cpEn;
    stb.excRi  = start & cpEn & ~vzPresent;
    stb.wrEn   = start & cpEn & vzPresent;
    stb.useFix = (pageMask == FIX_MASK);
    if (stb.useFix) tgtIdx = IDXW'(VTLB_N) + IDXW'(hiVpn2[MASKW +: FSELW]);
    else            tgtIdx = IDXW'(cnt);
  end

  assign randIdx = cnt;

  // R11
  rand_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wired <= LAST) |=> (cnt >= $past(wired)));
endmodule

// File: rtl/tlbw_datapath.sv
module tlbw_datapath
  import tlbw_pkg::*;
#(
  parameter int VTLB_N = 8,
  parameter int FTLB_N = 4,
  localparam int N    = VTLB_N + FTLB_N,
  localparam int IDXW = $clog2(N),
  localparam int EW   = $bits(tlbEntry_t)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [IDXW-1:0]   tgtIdx,
  input  logic              invEn,
  input  logic              guestEn,
  input  logic              radDis,
  input  logic              rootMode,
  input  logic [GIDW-1:0]   rootGid,
  input  logic [VPN2W-1:0]  hiVpn2,
  input  logic [ASIDW-1:0]  hiAsid,
  input  logic [1:0]        hiRegion,
  input  logic              hiInv,
  input  logic [PFNW-1:0]   lo0Pfn,
  input  logic [CACHEW-1:0] lo0C,
  input  logic              lo0D,
  input  logic              lo0V,
  input  logic              lo0G,
  input  logic [PFNW-1:0]   lo1Pfn,
  input  logic [CACHEW-1:0] lo1C,
  input  logic              lo1D,
  input  logic              lo1V,
  input  logic              lo1G,
  input  logic [MASKW-1:0]  pageMask,
  input  logic [IDXW-1:0]   probeIdx,
  output logic [EW-1:0]     probeEntry,
  output logic              done,
  output logic              excCpu,
  output logic              excRi,
  output logic [IDXW-1:0]   wrIdx
);
  function automatic logic [VPN2W-1:0] vMask(input logic [MASKW-1:0] m);
    return {{(VPN2W-MASKW){1'b0}}, m};
  endfunction
  function automatic logic [PFNW-1:0] pMask(input logic [MASKW-1:0] m);
    return {{(PFNW-MASKW){1'b0}}, m};
  endfunction

  tlbEntry_t       mem [N];
  tlbEntry_t       newEnt;
  logic [N-1:0]    dupHit;
  logic [N*EW-1:0] memFlat;
  logic            gForce;

  always_comb begin
    gForce      = guestEn & ~radDis & rootMode & (rootGid != '0);
    newEnt      = mem[tgtIdx];
    newEnt.mask   = pageMask;
    newEnt.region = hiRegion;
    newEnt.vpn2   = hiVpn2 & ~vMask(pageMask);
    newEnt.asid   = hiAsid;
    newEnt.g      = gForce | (lo0G & lo1G);
    newEnt.pfn0   = lo0Pfn & ~pMask(pageMask);
    newEnt.pfn1   = lo1Pfn & ~pMask(pageMask);
    newEnt.c0 = lo0C;  newEnt.d0 = lo0D;  newEnt.v0 = lo0V;
    newEnt.c1 = lo1C;  newEnt.d1 = lo1D;  newEnt.v1 = lo1V;
    if (invEn)   newEnt.hwInv = hiInv;
    if (guestEn) newEnt.gid   = rootGid;
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      dupHit[i] = !mem[i].hwInv && (IDXW'(i) != tgtIdx)
        && (((mem[i].vpn2 ^ newEnt.vpn2) & ~vMask(mem[i].mask | pageMask)) == '0)
        && ((mem[i].asid == newEnt.asid) || mem[i].g || newEnt.g);
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[i]       <= '0;
        mem[i].hwInv <= 1'b1;
      end else if (stb.wrEn) begin
        if (IDXW'(i) == tgtIdx) mem[i]       <= newEnt;
        else if (dupHit[i])     mem[i].hwInv <= 1'b1;
      end
    end

    assign memFlat[i*EW +: EW] = mem[i];

    // R10
    dup_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrEn && dupHit[i]) |=> mem[i].hwInv);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done   <= 1'b0;
      excCpu <= 1'b0;
      excRi  <= 1'b0;
      wrIdx  <= '0;
    end else begin
      done   <= stb.act;
      excCpu <= stb.excCpu;
      excRi  <= stb.excRi;
      if (stb.wrEn) wrIdx <= tgtIdx;
    end
  end

  assign probeEntry = mem[probeIdx];

  // R1
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(memFlat));
  // R5
  masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> (((mem[wrIdx].vpn2 & vMask(mem[wrIdx].mask)) == '0)
               && ((mem[wrIdx].pfn0 & pMask(mem[wrIdx].mask)) == '0)));
  // R2
  exc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(excCpu && excRi));
  // R12
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |=> done);
endmodule

// File: rtl/tlbw_top.sv
module tlbw_top
  import tlbw_pkg::*;
#(
  parameter int VTLB_N = 8,
  parameter int FTLB_N = 4,
  parameter logic [MASKW-1:0] FIX_MASK = '0
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   start,
  input  logic                                   cpEn,
  input  logic                                   vzPresent,
  input  logic                                   invEn,
  input  logic                                   guestEn,
  input  logic                                   radDis,
  input  logic                                   rootMode,
  input  logic [GIDW-1:0]                        rootGid,
  input  logic [$clog2(VTLB_N)-1:0]              wired,
  input  logic [VPN2W-1:0]                       hiVpn2,
  input  logic [ASIDW-1:0]                       hiAsid,
  input  logic [1:0]                             hiRegion,
  input  logic                                   hiInv,
  input  logic [PFNW-1:0]                        lo0Pfn,
  input  logic [CACHEW-1:0]                      lo0C,
  input  logic                                   lo0D,
  input  logic                                   lo0V,
  input  logic                                   lo0G,
  input  logic [PFNW-1:0]                        lo1Pfn,
  input  logic [CACHEW-1:0]                      lo1C,
  input  logic                                   lo1D,
  input  logic                                   lo1V,
  input  logic                                   lo1G,
  input  logic [MASKW-1:0]                       pageMask,
  input  logic [$clog2(VTLB_N+FTLB_N)-1:0]       probeIdx,
  output logic [$bits(tlbEntry_t)-1:0]           probeEntry,
  output logic                                   done,
  output logic                                   excCpu,
  output logic                                   excRi,
  output logic [$clog2(VTLB_N+FTLB_N)-1:0]       wrIdx,
  output logic [$clog2(VTLB_N)-1:0]              randIdx
);
  ctrlStb_t                            stb;
  logic [$clog2(VTLB_N+FTLB_N)-1:0]    tgtIdx;

  tlbw_ctrl #(.VTLB_N(VTLB_N), .FTLB_N(FTLB_N), .FIX_MASK(FIX_MASK)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cpEn(cpEn), .vzPresent(vzPresent),
    .pageMask(pageMask), .hiVpn2(hiVpn2), .wired(wired),
    .stb(stb), .tgtIdx(tgtIdx), .randIdx(randIdx)
  );

  tlbw_datapath #(.VTLB_N(VTLB_N), .FTLB_N(FTLB_N)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtIdx(tgtIdx),
    .invEn(invEn), .guestEn(guestEn), .radDis(radDis), .rootMode(rootMode),
    .rootGid(rootGid), .hiVpn2(hiVpn2), .hiAsid(hiAsid), .hiRegion(hiRegion),
    .hiInv(hiInv), .lo0Pfn(lo0Pfn), .lo0C(lo0C), .lo0D(lo0D), .lo0V(lo0V),
    .lo0G(lo0G), .lo1Pfn(lo1Pfn), .lo1C(lo1C), .lo1D(lo1D), .lo1V(lo1V),
    .lo1G(lo1G), .pageMask(pageMask), .probeIdx(probeIdx),
    .probeEntry(probeEntry), .done(done), .excCpu(excCpu), .excRi(excRi),
    .wrIdx(wrIdx)
  );
endmodule

// File: tb/test_tlbw_top.sv
`timescale 1ns/100ps
module test_tlbw_top;
  import tlbw_pkg::*;
  localparam int VN = 8, FN = 4, N = VN + FN;

  logic clk = 0, rstN = 0, start = 0, cpEn, vzPresent, invEn, guestEn, radDis, rootMode;
  logic [GIDW-1:0] rootGid;
  logic [2:0] wired;
  logic [VPN2W-1:0] hiVpn2;
  logic [ASIDW-1:0] hiAsid;
  logic [1:0] hiRegion;
  logic hiInv, lo0D, lo0V, lo0G, lo1D, lo1V, lo1G;
  logic [PFNW-1:0] lo0Pfn, lo1Pfn;
  logic [CACHEW-1:0] lo0C, lo1C;
  logic [MASKW-1:0] pageMask;
  logic [3:0] probeIdx = '0;
  logic [$bits(tlbEntry_t)-1:0] probeEntry;
  logic done, excCpu, excRi;
  logic [3:0] wrIdx;
  logic [2:0] randIdx;
  tlbEntry_t pe;
  assign pe = tlbEntry_t'(probeEntry);

  int nChk = 0, nFail = 0;
  bit finished = 0;
  tlbEntry_t snap [N];

  always #10 clk = ~clk;

  tlbw_top #(.VTLB_N(VN), .FTLB_N(FN), .FIX_MASK('0)) i_tlbw_top (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input int idx, output tlbEntry_t e);
    probeIdx = 4'(idx);
    #0.5;
    e = pe;
  endtask

  task automatic defaults();
    cpEn = 1; vzPresent = 1; invEn = 1; guestEn = 0; radDis = 0; rootMode = 0;
    rootGid = 0; wired = 0; hiVpn2 = 0; hiAsid = 0; hiRegion = 0; hiInv = 0;
    lo0Pfn = 0; lo0C = 0; lo0D = 0; lo0V = 0; lo0G = 0;
    lo1Pfn = 0; lo1C = 0; lo1D = 0; lo1V = 0; lo1G = 0; pageMask = 4'h1;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic snapAll();
    for (int i = 0; i < N; i++) rd(i, snap[i]);
  endtask

  task automatic cmpAll(input string req);
    tlbEntry_t e;
    for (int i = 0; i < N; i++) begin
      rd(i, e);
      chk(e == snap[i], req, 64'(e), 64'(snap[i]));
    end
  endtask

  // one write; avoid lists variable-array slots that must not be the target
  task automatic doWrite(input logic [15:0] avoid, output int idx);
    @(negedge clk);
    while (pageMask != 0 && avoid[randIdx]) @(negedge clk);
    idx = (pageMask == 0) ? VN + int'(hiVpn2[MASKW +: 2]) : int'(randIdx);
    start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1, "R12 done", 64'(done), 1);
    chk(wrIdx == 4'(idx), "R9/R12 wrIdx", 64'(wrIdx), 64'(idx));
    chk(!excCpu && !excRi, "R10 no exception", {excCpu, excRi}, 0);
  endtask

  task automatic testReset();
    tlbEntry_t e, z;
    defaults();
    doReset();
    chk(randIdx == 3'd7, "R11 reset index", randIdx, 7);
    chk(done == 0, "R12 idle done", done, 0);
    z = '0; z.hwInv = 1;
    rd(0, e);  chk(e == z, "R13 reset entry 0", 64'(e), 64'(z));
    rd(11, e); chk(e == z, "R13 reset entry 11", 64'(e), 64'(z));
  endtask

  task automatic testCounter();
    logic [2:0] prev, exp;
    wired = 3'd2;
    @(negedge clk);
    prev = randIdx;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      exp = (prev <= 3'd2) ? 3'd7 : prev - 3'd1;
      chk(randIdx == exp, "R11 step", randIdx, exp);
      prev = randIdx;
    end
    wired = 3'd0;
  endtask

  task automatic testBasic();
    int idx;
    tlbEntry_t e;
    defaults();
    hiVpn2 = 8'hB7; pageMask = 4'h3; hiAsid = 4'h5; hiRegion = 2'd2;
    lo0Pfn = 8'h5F; lo1Pfn = 8'hA6; lo0C = 3'd3; lo1C = 3'd5;
    lo0D = 1; lo0V = 0; lo1D = 0; lo1V = 1; lo0G = 1; lo1G = 0;
    doWrite('0, idx);
    chk(idx < VN, "R9 variable array", idx, 0);
    rd(idx, e);
    chk(e.vpn2 == 8'hB4, "R5 vpn2 masked", e.vpn2, 8'hB4);
    chk(e.pfn0 == 8'h5C && e.pfn1 == 8'hA4, "R5 pfn masked", {e.pfn0, e.pfn1}, 16'h5CA4);
    chk(e.mask == 4'h3 && e.asid == 4'h5 && e.region == 2'd2, "R5 copied fields",
        {e.mask, e.asid, e.region}, {4'h3, 4'h5, 2'd2});
    chk({e.c0, e.d0, e.v0} == {3'd3, 1'b1, 1'b0}, "R6 even half", {e.c0, e.d0, e.v0}, {3'd3, 2'b10});
    chk({e.c1, e.d1, e.v1} == {3'd5, 1'b0, 1'b1}, "R6 odd half", {e.c1, e.d1, e.v1}, {3'd5, 2'b01});
    chk(e.g == 0, "R3 global AND 1&0", e.g, 0);
    chk(e.hwInv == 0, "R7 hwInv cleared", e.hwInv, 0);
    lo1G = 1; hiAsid = 4'h6;
    doWrite('0, idx); rd(idx, e);
    chk(e.g == 1, "R3 global AND 1&1", e.g, 1);
  endtask

  task automatic testGuest();
    int idx;
    tlbEntry_t e;
    defaults();
    hiVpn2 = 8'h40; hiAsid = 4'h2;
    guestEn = 1; radDis = 0; rootMode = 1; rootGid = 3'd5;
    doWrite('0, idx); rd(idx, e);
    chk(e.g == 1, "R4 global forced", e.g, 1);
    chk(e.gid == 3'd5, "R8 guest id written", e.gid, 5);
    radDis = 1; hiVpn2 = 8'h60;
    doWrite('0, idx); rd(idx, e);
    chk(e.g == 0, "R4 no force with radDis", e.g, 0);
    radDis = 0; rootGid = 3'd0; hiVpn2 = 8'h70;
    doWrite('0, idx); rd(idx, e);
    chk(e.g == 0, "R4 no force with zero gid", e.g, 0);
  endtask

  task automatic testFixed();
    int idx;
    tlbEntry_t e;
    defaults();
    pageMask = 4'h0; hiVpn2 = 8'h2C; rootGid = 3'd6; guestEn = 1;
    doWrite('0, idx);
    chk(idx == 10, "R9 fixed array index", idx, 10);
    rd(10, e);
    chk(e.vpn2 == 8'h2C && e.hwInv == 0, "R9 fixed entry", {e.vpn2, e.hwInv}, {8'h2C, 1'b0});
    invEn = 0; hiInv = 1; guestEn = 0; rootGid = 3'd1;
    doWrite('0, idx); rd(10, e);
    chk(e.hwInv == 0, "R7 hwInv kept when disabled", e.hwInv, 0);
    chk(e.gid == 3'd6, "R8 gid kept when disabled", e.gid, 6);
    invEn = 1;
    doWrite('0, idx); rd(10, e);
    chk(e.hwInv == 1, "R7 hwInv set from hiInv", e.hwInv, 1);
  endtask

  task automatic testExc();
    defaults();
    hiVpn2 = 8'h99;
    snapAll();
    cpEn = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(done && excCpu && !excRi, "R1 unusable flag", {done, excCpu, excRi}, 3'b110);
    cmpAll("R1 entries unchanged");
    vzPresent = 0;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(excCpu && !excRi, "R2 unusable has priority", {excCpu, excRi}, 2'b10);
    cpEn = 1;
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk(done && !excCpu && excRi, "R2 reserved flag", {done, excCpu, excRi}, 3'b101);
    cmpAll("R2 entries unchanged");
    @(negedge clk);
    chk(!done && !excRi, "R12 done one cycle", {done, excRi}, 0);
  endtask

  task automatic testDup();
    int ia, ib, ic, id, ie, ig, ih;
    tlbEntry_t e;
    defaults();
    doReset();
    pageMask = 4'h1; hiVpn2 = 8'h30; hiAsid = 4'h1;
    doWrite('0, ia);
    hiAsid = 4'h2;
    doWrite(16'(1 << ia), ic);
    hiVpn2 = 8'h31; hiAsid = 4'h1;
    doWrite(16'((1 << ia) | (1 << ic)), ib);
    rd(ia, e); chk(e.hwInv == 1, "R10 match invalidated", e.hwInv, 1);
    rd(ic, e); chk(e.hwInv == 0, "R10 other ASID kept", e.hwInv, 0);
    rd(ib, e); chk(e.hwInv == 0 && e.vpn2 == 8'h30, "R10 new entry written", {e.hwInv, e.vpn2}, {1'b0, 8'h30});
    hiVpn2 = 8'h80; hiAsid = 4'h3; lo0G = 1; lo1G = 1;
    doWrite(16'((1 << ib) | (1 << ic)), id);
    hiAsid = 4'h4; lo0G = 0; lo1G = 0;
    doWrite(16'((1 << ib) | (1 << ic) | (1 << id)), ie);
    rd(id, e); chk(e.hwInv == 1, "R10 global match invalidated", e.hwInv, 1);
    rd(ie, e); chk(e.hwInv == 0, "R10 write completes", e.hwInv, 0);
    pageMask = 4'h3; hiVpn2 = 8'h50; hiAsid = 4'h1;
    doWrite(16'((1 << ib) | (1 << ic) | (1 << ie)), ig);
    pageMask = 4'h1; hiVpn2 = 8'h52;
    doWrite(16'((1 << ib) | (1 << ic) | (1 << ie) | (1 << ig)), ih);
    rd(ig, e); chk(e.hwInv == 1, "R10 combined mask match", e.hwInv, 1);
    rd(ib, e); chk(e.hwInv == 0, "R10 unrelated kept", e.hwInv, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    testReset();
    testCounter();
    testBasic();
    testGuest();
    testFixed();
    testExc();
    testDup();
    finish();
  end
endmodule